// File: doc/BRIEF.md
# Branch Destination Trace Queue

This block is a debug history buffer. Every time the processor core takes a branch, it presents the target address on a strobe. The block keeps the most recent destinations in a fixed eight-slot history. Each new capture pushes the older entries one slot further back. Once all eight slots are full, the oldest destination is dropped.

A debugger reads the history one word at a time through a simple read port. Each 32-bit word holds a valid flag, three zero bits and the low 28 bits of a stored destination. A read returns the oldest entry that is still valid and then clears that entry's flag, so repeated reads walk from the oldest entry to the newest.

Tracing is controlled by a level input. Turning it on clears every flag, so that a debugger only sees branches taken after the trace was armed. The power-on reset also clears the flags. The stored address bits are never reset.

The branch input, the read port and the write port are valid/ready channels. All three ready outputs are held high, so the block never applies back-pressure:
- A branch strobe is consumed in the cycle its valid is high.
- A read is consumed in the cycle its valid is high, and the word it returns is the one on `rd_word` during that cycle.
- A write is accepted and discarded.

Top module: `bdtq_trace_queue`

## Requirements
- R1: The history holds 8 slots, numbered 0 for the newest and 7 for the oldest. Each capture moves slot i into slot i+1 and writes the new destination into slot 0. When a capture arrives with slot 7 occupied, the destination in slot 7 is discarded.
- R2: Only bits 27..0 of the 32-bit branch address are stored. Bits 31..28 of the input have no effect.
- R3: The read word is arranged as follows: bit 31 is the valid flag, bits 30..28 are zero, and bits 27..0 are the stored address.
- R4: A capture sets the valid flag of slot 0.
- R5: `rd_word` shows the highest-numbered slot whose flag is set. A read (`rd_valid` high at a clock edge) clears that slot's flag.
- R6: When no flag is set, `rd_word` has bit 31 clear and carries the address held in slot 7.
- R7: In the first cycle that `trace_en` is seen high after being low, all flags are cleared. A branch presented in that same cycle is still captured.
- R8: While `trace_en` is low, branch strobes are accepted but dropped, and the slot contents do not change.
- R9: Driving `por_n` low clears every flag and the arming history at once. The stored addresses keep their values.
- R10: Write transfers change nothing visible on the read port.
- R11: When a read and a capture share a cycle, the word returned is the one from before the shift. The read's flag is cleared first, and then the shift applies.
- R12: `br_ready`, `rd_ready` and `wr_ready` are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trace_en | input | 1 | Trace enable level; a rising level arms the trace |
| br_valid | input | 1 | Taken-branch strobe |
| br_ready | output | 1 | Always high |
| br_addr | input | 32 | Branch destination address |
| rd_valid | input | 1 | Read request; consumes the presented word |
| rd_ready | output | 1 | Always high |
| rd_word | output | 32 | Presented trace word (combinational from state) |
| wr_valid | input | 1 | Write request (discarded) |
| wr_ready | output | 1 | Always high |
| wr_data | input | 32 | Write data (discarded) |

## Verification
`rd_word` is a direct function of the flag vector and the slot contents, so a fault in either shows up on the port in the cycle right after the edge that caused it:
- A flag left set, or cleared at the wrong time, changes bit 31, or changes which slot the word points at.
- A wrong shift changes the address field as soon as the debugger reads that slot.

The bench therefore compares the whole word against a behavioural history on every cycle. Problems in the slots behind the oldest valid entry become visible only once reads have drained the entries ahead of them. The directed phases do that draining, so each slot is exposed within eight reads.

// File: rtl/bdtq_pkg.sv
package bdtq_pkg;
  localparam int unsigned TRACE_DEPTH  = 8;
  localparam int unsigned TRACE_ADDR_W = 28;
  localparam int unsigned TRACE_WORD_W = 32;
  localparam int unsigned TRACE_IN_W   = 32;
endpackage

// File: rtl/bdtq_store.sv
module bdtq_store #(
  parameter int unsigned DEPTH  = bdtq_pkg::TRACE_DEPTH,
  parameter int unsigned ADDR_W = bdtq_pkg::TRACE_ADDR_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] slots [DEPTH]
);
  // Address slots are deliberately left without reset.
  always_ff @(posedge clk) begin
    if (cap) begin
      slots[0] <= cap_addr;
      for (int i = 1; i < DEPTH; i++) slots[i] <= slots[i-1];
    end
  end

  assert_shift_R1: assert property (@(posedge clk) disable iff (!por_n)
    cap |=> (slots[1] == $past(slots[0]) && slots[DEPTH-1] == $past(slots[DEPTH-2])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
    !cap |=> (slots[0] == $past(slots[0]) && slots[DEPTH-1] == $past(slots[DEPTH-1])));
endmodule

// File: rtl/bdtq_flags.sv
module bdtq_flags #(
  parameter int unsigned DEPTH = bdtq_pkg::TRACE_DEPTH
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             arm,
  input  logic             cap,
  input  logic [DEPTH-1:0] clr_mask,
  output logic [DEPTH-1:0] flags
);
  logic [DEPTH-1:0] after_rd, after_arm, nxt;

  always_comb begin
    after_rd  = flags & ~clr_mask;
    after_arm = arm ? '0 : after_rd;
    nxt       = cap ? {after_arm[DEPTH-2:0], 1'b1} : after_arm;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flags <= '0;
    else        flags <= nxt;
  end

  assert_capture_sets_R4: assert property (@(posedge clk) disable iff (!por_n)
    cap |=> flags[0]);

  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    (arm && !cap) |=> (flags == '0));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!por_n)
    (!cap && !arm && clr_mask != '0) |=> ((flags & $past(clr_mask)) == '0));

  always_ff @(posedge clk) begin
    if (!por_n) assert_por_clears_R9: assert (flags == '0);
  end
endmodule

// File: rtl/bdtq_select.sv
module bdtq_select #(
  parameter int unsigned DEPTH  = bdtq_pkg::TRACE_DEPTH,
  parameter int unsigned ADDR_W = bdtq_pkg::TRACE_ADDR_W,
  parameter int unsigned WORD_W = bdtq_pkg::TRACE_WORD_W
) (
  input  logic [DEPTH-1:0]  flags,
  input  logic [ADDR_W-1:0] slots [DEPTH],
  output logic [DEPTH-1:0]  sel_oh,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned PAD_W = WORD_W - 1 - ADDR_W;

  // Oldest valid slot wins: highest index with its flag set.
  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    if (i == DEPTH - 1) begin : g_top
      assign sel_oh[i] = flags[i];
    end else begin : g_low
      assign sel_oh[i] = flags[i] & ~(|flags[DEPTH-1:i+1]);
    end
  end

  logic [ADDR_W-1:0] addr;
  always_comb begin
    addr = slots[DEPTH-1];
    for (int i = 0; i < DEPTH; i++) if (sel_oh[i]) addr = slots[i];
  end

  assign word = {|flags, {PAD_W{1'b0}}, addr};
endmodule

// File: rtl/bdtq_trace_queue.sv
module bdtq_trace_queue #(
  parameter int unsigned DEPTH  = bdtq_pkg::TRACE_DEPTH,
  parameter int unsigned ADDR_W = bdtq_pkg::TRACE_ADDR_W,
  parameter int unsigned WORD_W = bdtq_pkg::TRACE_WORD_W,
  parameter int unsigned IN_W   = bdtq_pkg::TRACE_IN_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              trace_en,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [IN_W-1:0]   br_addr,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data
);
  logic              en_q;
  logic              arm, cap;
  logic [DEPTH-1:0]  flags, sel_oh, clr_mask;
  logic [ADDR_W-1:0] slots [DEPTH];
  logic              unused_bits;

  assign unused_bits = ^{wr_valid, wr_data, br_addr[IN_W-1:ADDR_W]};

  assign br_ready = 1'b1;
  assign rd_ready = 1'b1;
  assign wr_ready = 1'b1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) en_q <= 1'b0;
    else        en_q <= trace_en;
  end

  assign arm      = trace_en & ~en_q;
  assign cap      = br_valid & trace_en;
  assign clr_mask = rd_valid ? sel_oh : '0;

  bdtq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .por_n(por_n), .cap(cap),
    .cap_addr(br_addr[ADDR_W-1:0]), .slots(slots));

  bdtq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .por_n(por_n), .arm(arm), .cap(cap),
    .clr_mask(clr_mask), .flags(flags));

  bdtq_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_sel (
    .flags(flags), .slots(slots), .sel_oh(sel_oh), .word(rd_word));

  assert_flag_bit_R3: assert property (@(posedge clk) disable iff (!por_n)
    rd_word[WORD_W-1] == (flags != '0));

  assert_one_pick_R5: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(clr_mask));

  assert_no_backpressure_R12: assert property (@(posedge clk) disable iff (!por_n)
    br_ready && rd_ready && wr_ready);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!rd_valid && !cap && !arm) |=> $stable(flags));
endmodule

// File: tb/bdtq_trace_queue_bench.sv
module bdtq_trace_queue_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        por_n, trace_en, br_valid, rd_valid, wr_valid;
  logic        br_ready, rd_ready, wr_ready;
  logic [31:0] br_addr, wr_data, rd_word;

  bdtq_trace_queue u_bdtq_trace_queue (
    .clk(clk), .por_n(por_n), .trace_en(trace_en),
    .br_valid(br_valid), .br_ready(br_ready), .br_addr(br_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data));

  logic [27:0] m_addr [8];
  bit          m_known[8];
  bit          m_flag [8];
  bit          m_enq;
  int          n_tests = 0;
  int          n_fail  = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int oldest();
    for (int i = 7; i >= 0; i--) if (m_flag[i]) return i;
    return -1;
  endfunction

  task automatic step(string tag, bit en, bit bv, logic [31:0] ba,
                      bit rv, bit wv = 0, logic [31:0] wd = '0, bit por = 1);
    int idx, s;
    logic [31:0] exp;
    @(negedge clk);
    por_n = por; trace_en = en; br_valid = bv; br_addr = ba;
    rd_valid = rv; wr_valid = wv; wr_data = wd;
    if (!por) begin
      for (int i = 0; i < 8; i++) m_flag[i] = 0;
      m_enq = 0;
    end
    #1;
    idx = oldest();
    s   = (idx < 0) ? 7 : idx;
    exp = {(idx >= 0), 3'b000, m_addr[s]};
    chk(rd_word[31] === exp[31], tag, rd_word, exp);
    chk(rd_word[30:28] === 3'b000, "R3", rd_word, exp);
    if (m_known[s]) chk(rd_word[27:0] === exp[27:0], tag, rd_word, exp);
    chk(br_ready === 1'b1 && rd_ready === 1'b1 && wr_ready === 1'b1, "R12",
        {29'd0, br_ready, rd_ready, wr_ready}, 32'd7);
    @(posedge clk);
    if (por) begin
      if (rv && idx >= 0) m_flag[idx] = 0;
      if (en && !m_enq) for (int i = 0; i < 8; i++) m_flag[i] = 0;
      if (bv && en) begin
        for (int i = 7; i > 0; i--) begin
          m_addr[i] = m_addr[i-1]; m_known[i] = m_known[i-1]; m_flag[i] = m_flag[i-1];
        end
        m_addr[0] = ba[27:0]; m_known[0] = 1; m_flag[0] = 1;
      end
      m_enq = en;
    end
  endtask

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_known[i] = 0; m_flag[i] = 0; m_addr[i] = '0; end
    m_enq = 0;
    por_n = 0; trace_en = 0; br_valid = 0; rd_valid = 0; wr_valid = 0;
    br_addr = '0; wr_data = '0;
    repeat (3) step("R9", 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0);

    // R7/R4/R2: arm, then three captures with junk in the upper nibble
    step("R7", 1, 0, 0, 0);
    step("R2", 1, 1, 32'hF123_4567, 0);
    step("R4", 1, 1, 32'hA000_0ABC, 0);
    step("R2", 1, 1, 32'h5FFF_FFFF, 0);
    for (int k = 0; k < 3; k++) step("R5", 1, 0, 0, 1);
    step("R6", 1, 0, 0, 1);

    // R1: ten captures overflow, then drain
    for (int k = 0; k < 10; k++) step("R1", 1, 1, 32'h0100_0000 + k * 32'h11, 0);
    for (int k = 0; k < 9; k++) step("R1", 1, 0, 0, 1);
    step("R6", 1, 0, 0, 0);

    // R8: disabled, strobes dropped
    for (int k = 0; k < 4; k++) step("R8", 0, 1, 32'h0BAD_0000 + k, 0);
    step("R8", 0, 0, 0, 1);

    // R7: re-arm with flags set, branch in arm cycle
    step("R7", 1, 0, 0, 0);
    step("R7", 1, 1, 32'h0000_1111, 0);
    step("R7", 1, 1, 32'h0000_2222, 0);
    step("R7", 0, 0, 0, 0);
    step("R7", 1, 1, 32'h0000_3333, 0);
    step("R7", 1, 0, 0, 1);
    step("R7", 1, 0, 0, 1);

    // R10: writes ignored
    step("R10", 1, 1, 32'h0000_4444, 0);
    for (int k = 0; k < 4; k++) step("R10", 1, 0, 0, 0, 1, 32'hFFFF_FFFF ^ k);
    step("R10", 1, 0, 0, 1);

    // R11: read and capture together
    for (int k = 0; k < 3; k++) step("R11", 1, 1, 32'h0700_0000 + k, 0);
    for (int k = 0; k < 6; k++) step("R11", 1, 1, 32'h0800_0000 + k, 1);
    for (int k = 0; k < 9; k++) step("R11", 1, 0, 0, 1);

    // R9: reset mid-run keeps addresses
    for (int k = 0; k < 8; k++) step("R9", 1, 1, 32'h0900_0000 + k * 32'h101, 0);
    step("R9", 1, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1);
    step("R9", 1, 0, 0, 1);

    for (int k = 0; k < 400; k++)
      step("R5", ($urandom % 8) != 0, $urandom % 2, $urandom, $urandom % 2,
           $urandom % 2, $urandom);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule